// File: doc/BRIEF.md
# Programmable Integer Clock Divider

This block derives a slower clock from its input clock by a whole-number ratio chosen at run time. A synchronous wrap-around counter steps through one state per input cycle and returns to zero after the last state. Three results come from that counter: the count value itself, whose low bits serve as binary power-of-two taps; a one-cycle terminal pulse; and a divided clock.

The divided clock keeps a 50% duty cycle for every ratio. Even ratios are shaped on the rising edge alone. Odd ratios add a single half-cycle stage clocked on the falling edge, which trims the long phase by half an input period. A ratio of one hands the input clock straight through.

A new ratio written on the divisor input is taken up only at the end of the running period, so the output never shows a shortened pulse. Zero on the divisor input is read as one. All state shares the single input clock and is cleared by a synchronous active-high reset.

Top module: `clock_divider`

## Requirements
- R1: With active ratio N (1 to 2^CW-1), `count` runs 0, 1, ..., N-1 and then returns to 0 on the next enabled rising edge, so one output period spans exactly N input cycles and no extra state is held.
- R2: `tc` is high for exactly one input cycle per period, namely the cycle in which `count` is 0 just after a wrap. For N=1 it stays high.
- R3: For even N, `clk_div` is high while `count` is below N/2 and low otherwise. This gives N/2 cycles high and N/2 cycles low, driven only from the rising edge.
- R4: For odd N above 1, `clk_div` is high for exactly N half-periods of the input clock out of every 2N. It rises half a cycle after the wrap and falls on the rising edge at which `count` reaches (N+1)/2.
- R5: With N=1, `clk_div` follows the input clock. A value of 0 on `div_in` behaves exactly as 1.
- R6: A change on `div_in` takes effect only at the next wrap. The running period completes with the old ratio.
- R7: While `en` is low, `count` holds its value and `tc` is low. For N above 1, `clk_div` also holds its value.
- R8: While `rst` is high at a rising edge, `count` clears to 0, `tc` goes low, `clk_div` goes low and the active ratio returns to 1.
- R9: With N = 2^m, bit k of `count` (k < m) toggles once every 2^k input cycles, so it runs at the input rate divided by 2^(k+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all state uses it (rising edge, plus one falling-edge stage) |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; low pauses the divider |
| div_in | input | CW | Requested division ratio, 0 read as 1 |
| count | output | CW | Current counter state; low bits are power-of-two taps |
| tc | output | 1 | Terminal pulse, one cycle per period |
| clk_div | output | 1 | Divided clock with 50% duty cycle |

## Verification
The hardest case to reach is a change of ratio in the middle of a period, crossing between odd and even shaping. At that point the falling-edge stage still holds the old phase while the counter and shaping mode switch over. The stimulus waits until the count reaches a chosen interior value before writing a new ratio. It then counts the cycles to the next terminal pulse to confirm that the old period ran to its end. Duty cycle is measured by sampling `clk_div` in both halves of each input cycle, so the half-cycle trim for odd ratios shows up as a count of high samples that equals N.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // How the divided clock is formed from the counter phase.
  typedef enum logic [1:0] {
    SHAPE_EVEN = 2'd0,
    SHAPE_ODD  = 2'd1,
    SHAPE_PASS = 2'd2
  } shape_e;

  function automatic shape_e pick_shape(input logic is_one, input logic is_odd);
    if (is_one)      return SHAPE_PASS;
    else if (is_odd) return SHAPE_ODD;
    return SHAPE_EVEN;
  endfunction

endpackage

// File: rtl/clkdiv_reload.sv
module clkdiv_reload
  import clkdiv_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wrap,
  input  logic [CW-1:0] div_in,
  output logic [CW-1:0] div_q,
  output shape_e        shape_q
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] div_eff;

  // R5: a zero request is the same as divide-by-one.
  assign div_eff = (div_in == '0) ? ONE : div_in;

  // R6: the ratio and its shaping mode change only at a wrap.
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= ONE;
      shape_q <= SHAPE_EVEN;
    end else if (en && wrap) begin
      div_q   <= div_eff;
      shape_q <= pick_shape(div_eff == ONE, div_eff[0]);
    end
  end

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] div_q,
  output logic [CW-1:0] count_q,
  output logic          wrap,
  output logic          tc_q
);

  // Last state of the period; div_q is never zero.
  assign wrap = (count_q == div_q - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      tc_q    <= 1'b0;
    end else begin
      tc_q <= en & wrap;
      if (en) begin
        count_q <= wrap ? '0 : count_q + CW'(1);
      end
    end
  end

endmodule

// File: rtl/clkdiv_shaper.sv
module clkdiv_shaper
  import clkdiv_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          wrap,
  input  logic [CW-1:0] count_q,
  input  logic [CW-1:0] div_q,
  input  shape_e        shape_q,
  output logic          clk_div
);

  localparam int EW = CW + 1;

  logic [EW-1:0] half_len;
  logic [EW-1:0] next_pos;
  logic          rise_q;
  logic          fall_q;

  // Rising-edge phase is high for ceil(N/2) states starting at 0.
  assign half_len = EW'(div_q >> 1) + EW'(div_q[0]);
  assign next_pos = EW'(count_q) + EW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_q <= 1'b0;
    end else if (en) begin
      rise_q <= wrap | (next_pos < half_len);
    end
  end

  // Half-cycle delayed copy for odd ratios.
  always_ff @(negedge clk) begin
    if (rst) begin
      fall_q <= 1'b0;
    end else begin
      fall_q <= rise_q;
    end
  end

  always_comb begin
    case (shape_q)
      SHAPE_PASS: clk_div = clk;
      SHAPE_ODD:  clk_div = rise_q & fall_q;
      default:    clk_div = rise_q;
    endcase
  end

endmodule

// File: rtl/clock_divider.sv
module clock_divider
  import clkdiv_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] div_in,
  output logic [CW-1:0] count,
  output logic          tc,
  output logic          clk_div
);

  logic [CW-1:0] div_q;
  shape_e        shape_q;
  logic          wrap;

  clkdiv_reload #(.CW(CW)) u_reload (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .wrap    (wrap),
    .div_in  (div_in),
    .div_q   (div_q),
    .shape_q (shape_q)
  );

  clkdiv_counter #(.CW(CW)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .div_q   (div_q),
    .count_q (count),
    .wrap    (wrap),
    .tc_q    (tc)
  );

  clkdiv_shaper #(.CW(CW)) u_shaper (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .wrap    (wrap),
    .count_q (count),
    .div_q   (div_q),
    .shape_q (shape_q),
    .clk_div (clk_div)
  );

endmodule

// File: rtl/clock_divider_chk.sv
module clock_divider_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [CW-1:0] count,
  input logic          tc,
  input logic          clk_div,
  input logic [CW-1:0] div_q
);

  p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
    count < div_q);

  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    (en && (count != div_q - CW'(1))) |=> (count == $past(count) + CW'(1)));

  p_tc_at_zero_r2: assert property (@(posedge clk) disable iff (rst)
    tc |-> (count == '0));

  p_even_duty_r3: assert property (@(posedge clk) disable iff (rst)
    (!div_q[0]) |-> (clk_div == (count < (div_q >> 1))));

  p_reload_at_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(div_q) |-> (count == '0));

  p_pause_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(count) && !tc));

endmodule

bind clock_divider clock_divider_chk #(.CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .count   (count),
  .tc      (tc),
  .clk_div (clk_div),
  .div_q   (div_q)
);

// File: tb/clock_divider_tb.sv
module clock_divider_tb;

  localparam int CW = 8;
  localparam int NV = 8;
  // Stimulus ratio and expected period length per vector.
  localparam logic [CW-1:0] VEC_DIV [NV] = '{8'd1, 8'd0, 8'd2, 8'd3, 8'd4, 8'd7, 8'd10, 8'd255};
  localparam int            VEC_PER [NV] = '{1, 1, 2, 3, 4, 7, 10, 255};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en  = 1'b0;
  logic [CW-1:0] div_in = 8'd1;
  logic [CW-1:0] count;
  logic          tc;
  logic          clk_div;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [CW-1:0] s_cnt;
  logic          s_tc, s_hi, s_lo;

  clock_divider #(.CW(CW)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .div_in  (div_in),
    .count   (count),
    .tc      (tc),
    .clk_div (clk_div)
  );

  always #4 clk = ~clk;

  // Sample in the high half (+2) and low half (+6) of each input cycle.
  task automatic step();
    @(posedge clk);
    #2;
    s_cnt = count;
    s_tc  = tc;
    s_hi  = clk_div;
    #4;
    s_lo  = clk_div;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tc(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!s_tc && n < 1000);
  endtask

  task automatic wait_count(input int v);
    int n = 0;
    do begin
      step();
      n++;
    end while (s_cnt != CW'(v) && n < 1000);
  endtask

  // One full period after the next terminal pulse.
  task automatic measure(input int per, input string duty_tag);
    int n;
    int highs = 0;
    int tcs = 0;
    int bad = -1;
    wait_tc(n);
    for (int i = 0; i < per; i++) begin
      if (i > 0) step();
      if (s_cnt != CW'(i) && bad < 0) bad = i;
      highs += int'(s_hi) + int'(s_lo);
      tcs   += int'(s_tc);
    end
    step();
    check(bad < 0 && s_cnt == '0, "R1 count runs 0..N-1 then wraps", bad, -1);
    check(tcs == 1 && s_tc, "R2 one terminal pulse per period", tcs, 1);
    check(highs == per, duty_tag, highs, per);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int tog [5];
    logic [CW-1:0] prev;

    // R8: reset state.
    repeat (3) step();
    check(s_cnt == '0, "R8 count cleared in reset", s_cnt, 0);
    check(!s_tc, "R8 tc low in reset", s_tc, 0);
    check(!s_hi && !s_lo, "R8 clk_div low in reset", s_hi + s_lo, 0);
    rst = 1'b0;
    en  = 1'b1;

    // Vector table: ratio, expected period; duty counted in half-cycles.
    for (int v = 0; v < NV; v++) begin
      div_in = VEC_DIV[v];
      if (VEC_PER[v] == 1)           measure(VEC_PER[v], "R5 divide-by-one passes clock");
      else if (VEC_PER[v] % 2 == 1)  measure(VEC_PER[v], "R4 odd ratio 50% duty");
      else                           measure(VEC_PER[v], "R3 even ratio 50% duty");
    end

    // R6: reload mid-period waits for the wrap.
    div_in = 8'd10;
    measure(10, "R3 even ratio 50% duty");
    wait_count(3);
    div_in = 8'd4;
    wait_tc(n);
    check(n == 7, "R6 old ratio completes period", n, 7);
    measure(4, "R6 new ratio after wrap");

    // R7: pause holds state.
    div_in = 8'd5;
    measure(5, "R4 odd ratio 50% duty");
    wait_count(2);
    en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      step();
      check(s_cnt == 8'd2, "R7 count held while paused", s_cnt, 2);
      check(!s_tc, "R7 tc low while paused", s_tc, 0);
      check(s_hi && s_lo, "R7 clk_div held while paused", s_hi + s_lo, 2);
    end
    en = 1'b1;
    step();
    check(s_cnt == 8'd3, "R7 count resumes", s_cnt, 3);

    // R9: power-of-two taps.
    div_in = 8'd16;
    measure(16, "R3 even ratio 50% duty");
    for (int k = 0; k < 5; k++) tog[k] = 0;
    prev = s_cnt;
    for (int i = 0; i < 32; i++) begin
      step();
      for (int k = 0; k < 5; k++) if (s_cnt[k] != prev[k]) tog[k]++;
      prev = s_cnt;
    end
    for (int k = 0; k < 4; k++) check(tog[k] == (32 >> k), "R9 tap toggle rate", tog[k], 32 >> k);
    check(tog[4] == 0, "R9 tap above ratio idle", tog[4], 0);

    // R8: reset in mid-run with an odd ratio.
    div_in = 8'd5;
    measure(5, "R4 odd ratio 50% duty");
    wait_count(3);
    rst = 1'b1;
    for (int i = 0; i < 2; i++) begin
      step();
      check(s_cnt == '0 && !s_tc, "R8 mid-run reset clears counter", s_cnt + s_tc, 0);
      check(!s_hi && !s_lo, "R8 mid-run reset drives clk_div low", s_hi + s_lo, 0);
    end
    rst = 1'b0;
    div_in = 8'd0;
    measure(1, "R5 zero ratio acts as one");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule